// File: doc/BRIEF.md
# Serial Flash Word Fetch Controller

This block reads one 32-bit word from an external serial flash. Software writes a 24-bit target address, clears the data register, and then writes the control register with the go bit set. The controller drops chip-select and sends a command byte taken from one of eight writable opcode registers. It then sends the address most-significant bit first and clocks in 32 data bits, also most-significant bit first. Once the last bit is captured and chip-select has risen, the go bit clears and the data register holds the word.

Timing comes from five 4-bit cycle counts in the control register, all in system-clock cycles: chip-select setup, clock-high, clock-low, chip-select hold and minimum chip-select idle-high. The serial port runs in mode 0, so SCK idles low and MISO is sampled on each rising SCK edge. The register port is a plain write strobe with a combinational read mux. It has no back-pressure: a write is taken in the cycle its strobe is high, and writes the block does not accept are dropped.

Register words, by index on `reg_addr`: 0 control, 1 address (bits 23:0), 2 data, 8 to 15 opcode registers 0 to 7 (bits 7:0). Other indices read as zero. Control bits: 0 go, 1 wait-ready, 7:4 setup, 11:8 clock-high, 15:12 clock-low, 19:16 hold, 23:20 idle-high, 26:24 command select.

Top module: `spiw_flash_reader`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and control reads 0x01322220. That value means go 0, wait-ready 0, setup 2, clock-high 2, clock-low 2, hold 2, idle-high 3 and command select 1. Opcode register 1 (index 9) reads 0x03.
- R2: Opcode registers 0 to 7 reset to 0x01, 0x03, 0x02, 0x06, 0x05, 0x9F, 0xD8 and 0xC7. Each is writable and reads back its low 8 bits. The command select field picks which opcode register is sent as the first byte.
- R3: A control write with bit 0 (go) set starts a transfer only if bit 1 (wait-ready) is also set in the same write. Otherwise go reads back 0 and `spi_cs_n` stays high.
- R4: One transfer is a single chip-select-low window with exactly 64 rising SCK edges. The first 8 carry the opcode on MOSI, the next 24 carry address bits 23 down to 0, and the last 32 sample MISO into data bits 31 down to 0.
- R5: SCK is low whenever chip-select is high, including at the edge where chip-select falls. MOSI changes only while SCK is low, and MISO is sampled as SCK rises.
- R6: Chip-select stays low for exactly setup + 64 × (clock-high + clock-low) + hold cycles, where any count of 0 counts as 1. Each SCK high phase lasts the clock-high count.
- R7: After chip-select rises, it stays high for at least the idle-high count before it falls again. A go written during that gap is ignored and reads back 0.
- R8: Go reads 1 from the accepting write until the cycle chip-select rises. From then on, the data register holds the captured word.
- R9: While a transfer or its idle gap is in progress, writes to the control and data registers are ignored, and the fields read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| spi_sck | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Active-low chip-select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The checker watches the serial pins on every cycle. It confirms that SCK is parked low while chip-select is high and at the falling chip-select edge, and that MOSI holds steady through each high phase. It also checks that every high phase lasts at least the clock-high count, that each chip-select window contains 64 rising SCK edges, and that go stays set whenever chip-select is low. The bench scenarios are needed for the rest: the opcode and address a flash model actually received, the returned word, the exact window length for zero and maximum counts, and the minimum idle gap. The same applies to writes that are ignored, which only show up as unchanged read-back and unchanged pin behaviour.

// File: rtl/spiw_pkg.sv
`timescale 1ns/1ps
package spiw_pkg;
  localparam int TW      = 4;   // width of one timing count
  localparam int NOPC    = 8;   // number of opcode registers
  localparam int OPW     = 8;   // opcode width
  localparam int CSW     = $clog2(NOPC);

  // register word indices
  localparam logic [3:0] RIX_CTRL = 4'd0;
  localparam logic [3:0] RIX_ADDR = 4'd1;
  localparam logic [3:0] RIX_DATA = 4'd2;
  localparam logic [3:0] RIX_OPC0 = 4'd8;

  // control word bit positions
  localparam int B_GO    = 0;
  localparam int B_WAIT  = 1;
  localparam int L_SETUP = 4;
  localparam int L_HI    = 8;
  localparam int L_LO    = 12;
  localparam int L_HOLD  = 16;
  localparam int L_IDLE  = 20;
  localparam int L_CMD   = 24;

  typedef struct packed {
    logic [TW-1:0] setup;
    logic [TW-1:0] hi;
    logic [TW-1:0] lo;
    logic [TW-1:0] hold;
    logic [TW-1:0] idle;
  } timing_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_HIGH, PH_LOW, PH_HOLD, PH_GAP
  } phase_e;

  function automatic logic [OPW-1:0] opc_reset(input int idx);
    case (idx)
      0: return 8'h01;
      1: return 8'h03;
      2: return 8'h02;
      3: return 8'h06;
      4: return 8'h05;
      5: return 8'h9F;
      6: return 8'hD8;
      default: return 8'hC7;
    endcase
  endfunction
endpackage

// File: rtl/spiw_countdown.sv
`timescale 1ns/1ps
// Phase timer: a load of N (0 taken as 1) makes zero go high after N-1 further cycles.
module spiw_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/spiw_engine.sv
`timescale 1ns/1ps
module spiw_engine
  import spiw_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  timing_t        tcfg,
  input  logic [OPW-1:0] opcode,
  input  logic [AW-1:0]  addr,
  input  logic           miso,
  output logic           sck,
  output logic           cs_n,
  output logic           mosi,
  output logic           idle,
  output logic           done,
  output logic [DW-1:0]  word
);
  localparam int HW    = OPW + AW;
  localparam int NBITS = HW + DW;
  localparam int BCW   = $clog2(NBITS + 1);

  phase_e         ph_q;
  logic [BCW-1:0] left_q;
  logic [HW-1:0]  tx_q;
  logic [DW-1:0]  rx_q;
  logic           sck_q, cs_q;
  logic           tmr_load, tmr_zero;
  logic [TW-1:0]  tmr_val;
  logic           last_bit;

  assign last_bit = (left_q == BCW'(1));

  spiw_countdown #(.W(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (ph_q)
      PH_IDLE:  if (start)    begin tmr_load = 1'b1; tmr_val = tcfg.setup; end
      PH_SETUP: if (tmr_zero) begin tmr_load = 1'b1; tmr_val = tcfg.hi;    end
      PH_HIGH:  if (tmr_zero) begin tmr_load = 1'b1; tmr_val = tcfg.lo;    end
      PH_LOW:   if (tmr_zero) begin
                  tmr_load = 1'b1;
                  tmr_val  = last_bit ? tcfg.hold : tcfg.hi;
                end
      PH_HOLD:  if (tmr_zero) begin tmr_load = 1'b1; tmr_val = tcfg.idle;  end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      left_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q   <= PH_SETUP;
          cs_q   <= 1'b0;
          tx_q   <= {opcode, addr};
          left_q <= BCW'(NBITS);
        end
        PH_SETUP: if (tmr_zero) begin
          ph_q  <= PH_HIGH;
          sck_q <= 1'b1;
          rx_q  <= {rx_q[DW-2:0], miso};
        end
        PH_HIGH: if (tmr_zero) begin
          ph_q  <= PH_LOW;
          sck_q <= 1'b0;
          tx_q  <= {tx_q[HW-2:0], 1'b0};
        end
        PH_LOW: if (tmr_zero) begin
          if (last_bit) begin
            ph_q <= PH_HOLD;
          end else begin
            ph_q   <= PH_HIGH;
            left_q <= left_q - 1'b1;
            sck_q  <= 1'b1;
            rx_q   <= {rx_q[DW-2:0], miso};
          end
        end
        PH_HOLD: if (tmr_zero) begin
          ph_q <= PH_GAP;
          cs_q <= 1'b1;
        end
        PH_GAP: if (tmr_zero) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign sck  = sck_q;
  assign cs_n = cs_q;
  assign mosi = tx_q[HW-1];
  assign idle = (ph_q == PH_IDLE);
  assign done = (ph_q == PH_HOLD) && tmr_zero;
  assign word = rx_q;
endmodule

// File: rtl/spiw_regs.sv
`timescale 1ns/1ps
module spiw_regs
  import spiw_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [3:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           eng_idle,
  input  logic           eng_done,
  input  logic [DW-1:0]  eng_word,
  output logic           start_req,
  output logic           go,
  output timing_t        tcfg,
  output logic [OPW-1:0] opcode,
  output logic [AW-1:0]  addr
);
  logic           go_q, wait_q;
  timing_t        tm_q;
  logic [CSW-1:0] cmd_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;
  logic [OPW-1:0] opc_q [NOPC];
  logic           ctrl_wr;

  assign ctrl_wr   = reg_we && (reg_addr == RIX_CTRL) && eng_idle;
  assign start_req = ctrl_wr && reg_wdata[B_GO] && reg_wdata[B_WAIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q     <= 1'b0;
      wait_q   <= 1'b0;
      tm_q     <= '{setup: TW'(2), hi: TW'(2), lo: TW'(2), hold: TW'(2), idle: TW'(3)};
      cmd_q    <= CSW'(1);
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        go_q        <= start_req;
        wait_q      <= reg_wdata[B_WAIT];
        tm_q.setup  <= reg_wdata[L_SETUP +: TW];
        tm_q.hi     <= reg_wdata[L_HI    +: TW];
        tm_q.lo     <= reg_wdata[L_LO    +: TW];
        tm_q.hold   <= reg_wdata[L_HOLD  +: TW];
        tm_q.idle   <= reg_wdata[L_IDLE  +: TW];
        cmd_q       <= reg_wdata[L_CMD   +: CSW];
      end else if (eng_done) begin
        go_q <= 1'b0;
      end
      if (reg_we && reg_addr == RIX_ADDR)
        addr_q <= reg_wdata[AW-1:0];
      if (eng_done)
        data_q <= eng_word;
      else if (reg_we && reg_addr == RIX_DATA && eng_idle)
        data_q <= reg_wdata[DW-1:0];
    end
  end

  for (genvar i = 0; i < NOPC; i++) begin : g_opc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        opc_q[i] <= opc_reset(i);
      else if (reg_we && reg_addr == RIX_OPC0 + 4'(i))
        opc_q[i] <= reg_wdata[OPW-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RIX_CTRL) begin
      reg_rdata[B_GO]            = go_q;
      reg_rdata[B_WAIT]          = wait_q;
      reg_rdata[L_SETUP +: TW]   = tm_q.setup;
      reg_rdata[L_HI    +: TW]   = tm_q.hi;
      reg_rdata[L_LO    +: TW]   = tm_q.lo;
      reg_rdata[L_HOLD  +: TW]   = tm_q.hold;
      reg_rdata[L_IDLE  +: TW]   = tm_q.idle;
      reg_rdata[L_CMD   +: CSW]  = cmd_q;
    end else if (reg_addr == RIX_ADDR) begin
      reg_rdata[AW-1:0] = addr_q;
    end else if (reg_addr == RIX_DATA) begin
      reg_rdata[DW-1:0] = data_q;
    end else if (reg_addr >= RIX_OPC0) begin
      reg_rdata[OPW-1:0] = opc_q[CSW'(reg_addr - RIX_OPC0)];
    end
  end

  assign go     = go_q;
  assign tcfg   = tm_q;
  assign opcode = opc_q[cmd_q];
  assign addr   = addr_q;
endmodule

// File: rtl/spiw_flash_reader.sv
`timescale 1ns/1ps
module spiw_flash_reader
  import spiw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int AW = 24;
  localparam int DW = 32;

  logic           start_req, go, eng_idle, eng_done;
  logic [DW-1:0]  eng_word;
  timing_t        tcfg;
  logic [OPW-1:0] opcode;
  logic [AW-1:0]  fl_addr;

  spiw_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .eng_idle  (eng_idle),
    .eng_done  (eng_done),
    .eng_word  (eng_word),
    .start_req (start_req),
    .go        (go),
    .tcfg      (tcfg),
    .opcode    (opcode),
    .addr      (fl_addr)
  );

  spiw_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_req),
    .tcfg   (tcfg),
    .opcode (opcode),
    .addr   (fl_addr),
    .miso   (spi_miso),
    .sck    (spi_sck),
    .cs_n   (spi_cs_n),
    .mosi   (spi_mosi),
    .idle   (eng_idle),
    .done   (eng_done),
    .word   (eng_word)
  );
endmodule

// File: rtl/spiw_checker.sv
`timescale 1ns/1ps
module spiw_checker
  import spiw_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          spi_sck,
  input logic          spi_cs_n,
  input logic          spi_mosi,
  input logic          go,
  input logic [TW-1:0] tm_hi
);
  logic [7:0] hi_run, edge_cnt;
  logic       sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run   <= '0;
      edge_cnt <= '0;
      sck_d    <= 1'b0;
    end else begin
      sck_d    <= spi_sck;
      hi_run   <= spi_sck ? ((hi_run == 8'hFF) ? hi_run : hi_run + 1'b1) : 8'd0;
      edge_cnt <= spi_cs_n ? 8'd0 : edge_cnt + 8'(spi_sck && !sck_d);
    end
  end

  assert_sck_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  assert_cs_fall_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> !spi_sck);
  assert_mosi_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  assert_high_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sck) |-> (hi_run >= ((tm_hi == '0) ? 8'd1 : 8'(tm_hi))));
  assert_edge_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (edge_cnt == 8'd64));
  assert_go_covers_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> go);
endmodule

bind spiw_flash_reader spiw_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_sck  (spi_sck),
  .spi_cs_n (spi_cs_n),
  .spi_mosi (spi_mosi),
  .go       (go),
  .tm_hi    (tcfg.hi)
);

// File: tb/tb_spiw_flash_reader.sv
`timescale 1ns/1ps
module tb_spiw_flash_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  spiw_flash_reader dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- flash model ----------------
  function automatic logic [31:0] flash_word(input logic [23:0] a);
    return {a, a[7:0]} ^ 32'hC35A_0F96;
  endfunction

  int          fl_cnt = 0;
  logic [31:0] fl_cmd = 32'd0;

  always @(negedge spi_cs_n) begin fl_cnt = 0; fl_cmd = 32'd0; end
  always @(posedge spi_sck) begin
    if (fl_cnt < 32) fl_cmd = {fl_cmd[30:0], spi_mosi};
    fl_cnt = fl_cnt + 1;
  end
  always @(negedge spi_sck) begin
    if (fl_cnt >= 32 && fl_cnt < 64)
      spi_miso = flash_word(fl_cmd[23:0])[63 - fl_cnt];
  end

  // ---------------- pin measurement ----------------
  int low_cycles = 0;
  int high_run = 0;
  int last_gap = 0;
  logic cs_prev = 1'b1;
  always @(negedge clk) begin
    if (!spi_cs_n) low_cycles++;
    if (spi_cs_n) high_run++;
    else if (cs_prev) begin last_gap = high_run; high_run = 0; end
    cs_prev = spi_cs_n;
  end

  // ---------------- helpers ----------------
  function automatic int eff(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  function automatic logic [31:0] ctrl_word(input logic go, input logic wr,
      input logic [2:0] cmd, input logic [3:0] s, input logic [3:0] h,
      input logic [3:0] l, input logic [3:0] hd, input logic [3:0] idl);
    return {5'd0, cmd, idl, hd, l, h, s, 2'b00, wr, go};
  endfunction

  function automatic logic [7:0] opc_dflt(input int i);
    case (i)
      0: return 8'h01; 1: return 8'h03; 2: return 8'h02; 3: return 8'h06;
      4: return 8'h05; 5: return 8'h9F; 6: return 8'hD8; default: return 8'hC7;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 5000; k++) begin
      rd(4'd0, v);
      if (!v[0]) break;
    end
  endtask

  // vector: addr, cmd, setup, hi, lo, hold, idle
  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    {24'h000000, 4'd1, 4'd2, 4'd2, 4'd2, 4'd2, 4'd3},
    {24'hFFFFFF, 4'd1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    {24'hA5C31E, 4'd6, 4'd1, 4'd3, 4'd1, 4'd4, 4'd2},
    {24'h123456, 4'd7, 4'd15, 4'd1, 4'd15, 4'd1, 4'd1},
    {24'h800001, 4'd0, 4'd3, 4'd15, 4'd2, 4'd0, 4'd5},
    {24'h7E7E7E, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1}
  };

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int exp_low;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
    check("R1 sck", {31'd0, spi_sck}, 32'd0);
    rd(4'd0, v); check("R1 ctrl", v, 32'h0132_2220);
    rd(4'd9, v); check("R1 read opcode", v, 32'h03);

    // vector table: R2 R4 R6 R8
    for (int i = 0; i < NV; i++) begin
      logic [23:0] a; logic [2:0] c; logic [3:0] s, h, l, hd, idl;
      {a, c, s, h, l, hd, idl} = {VEC[i][47:24], VEC[i][22:0]};
      wr(4'd2, 32'd0);
      wr(4'd1, {8'd0, a});
      wr(4'd0, ctrl_word(1'b0, 1'b1, c, s, h, l, hd, idl));
      low_cycles = 0;
      wr(4'd0, ctrl_word(1'b1, 1'b1, c, s, h, l, hd, idl));
      wait_idle();
      rd(4'd2, v); check("R4 R8 data word", v, flash_word(a));
      check("R2 R4 opcode sent", {24'd0, fl_cmd[31:24]}, {24'd0, opc_dflt(int'(c))});
      check("R4 address sent", {8'd0, fl_cmd[23:0]}, {8'd0, a});
      exp_low = eff(s) + 64 * (eff(h) + eff(l)) + eff(hd);
      check("R6 cs low cycles", 32'(low_cycles), 32'(exp_low));
      repeat (20) @(negedge clk);
    end

    // R3: go without wait-ready is ignored
    wr(4'd0, ctrl_word(1'b1, 1'b0, 3'd1, 4'd2, 4'd2, 4'd2, 4'd2, 4'd3));
    rd(4'd0, v); check("R3 go stays 0", {31'd0, v[0]}, 32'd0);
    repeat (10) @(negedge clk);
    check("R3 cs stays high", {31'd0, spi_cs_n}, 32'd1);

    // R9: control and data writes ignored mid-transfer
    wr(4'd1, 32'h00_3C_5A_7E);
    wr(4'd0, ctrl_word(1'b0, 1'b1, 3'd1, 4'd2, 4'd8, 4'd8, 4'd2, 4'd3));
    low_cycles = 0;
    wr(4'd0, ctrl_word(1'b1, 1'b1, 3'd1, 4'd2, 4'd8, 4'd8, 4'd2, 4'd3));
    repeat (40) @(negedge clk);
    wr(4'd0, ctrl_word(1'b1, 1'b1, 3'd5, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1));
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd0, v);
    check("R9 ctrl unchanged", v, ctrl_word(1'b1, 1'b1, 3'd1, 4'd2, 4'd8, 4'd8, 4'd2, 4'd3));
    wait_idle();
    rd(4'd2, v); check("R9 R8 data after blocked write", v, flash_word(24'h3C5A7E));
    check("R9 timing kept", 32'(low_cycles), 32'(2 + 64 * 16 + 2));

    // R7: idle gap guard
    repeat (20) @(negedge clk);
    wr(4'd0, ctrl_word(1'b0, 1'b1, 3'd1, 4'd1, 4'd1, 4'd1, 4'd1, 4'd9));
    wr(4'd0, ctrl_word(1'b1, 1'b1, 3'd1, 4'd1, 4'd1, 4'd1, 4'd1, 4'd9));
    wait_idle();
    wr(4'd0, ctrl_word(1'b1, 1'b1, 3'd1, 4'd1, 4'd1, 4'd1, 4'd1, 4'd9));
    rd(4'd0, v); check("R7 go in gap ignored", {31'd0, v[0]}, 32'd0);
    for (int k = 0; k < 100; k++) begin
      wr(4'd0, ctrl_word(1'b1, 1'b1, 3'd1, 4'd1, 4'd1, 4'd1, 4'd1, 4'd9));
      rd(4'd0, v);
      if (v[0]) break;
    end
    check("R7 retry accepted", {31'd0, v[0]}, 32'd1);
    wait_idle();
    check("R7 gap at least idle", 32'(last_gap >= 9), 32'd1);

    // R2: rewritten opcode register is sent
    repeat (20) @(negedge clk);
    wr(4'd13, 32'h0000_00AB);
    rd(4'd13, v); check("R2 opcode readback", v, 32'hAB);
    wr(4'd1, 32'h00_00_0F_F0);
    wr(4'd0, ctrl_word(1'b0, 1'b1, 3'd5, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1));
    wr(4'd0, ctrl_word(1'b1, 1'b1, 3'd5, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1));
    wait_idle();
    check("R2 custom opcode sent", {24'd0, fl_cmd[31:24]}, 32'hAB);
    rd(4'd2, v); check("R4 data with custom opcode", v, flash_word(24'h000FF0));

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule